// File: doc/BRIEF.md
# Processor Trace Status Port

This block produces a real-time view of program execution while the processor keeps running at full speed. Each cycle the core reports what it retired through a set of one-hot-style event strobes. The block turns them into a 4-bit status code, so that an external analyser can follow control flow against the program image. The codes cover nothing retired, a sequential instruction, the first instruction at a taken-branch target, exception-handler entry and a software marker pulse. The marker pulse is meant as an external trigger for timing measurements.

A second 4-bit port carries operands that software writes for debug purposes. Byte, 16-bit word and 32-bit long-word operands are queued in a small FIFO and then sent one nibble per cycle, least-significant nibble first, with a valid qualifier. When the queue is full the block raises a stall request. The core then holds its write until the request drops, so no operand is ever lost. Neither port ever halts the processor.

Top module: `trace_status_port`

## Requirements
- R1: The status port is registered. The code for the events presented at a clock edge appears on `pst_o` after that edge. Code 4'b0000 means no instruction retired in that cycle.
- R2: A sequential retirement (`ev_seq`) alone yields status 4'b0001.
- R3: A taken-branch target retirement (`ev_branch`) yields status 4'b0101 unless an exception entry is also present.
- R4: Exception entry (`ev_exc`) yields status 4'b1100 regardless of the other strobes.
- R5: A marker pulse (`ev_mark`) yields status 4'b0100 when neither an exception nor a branch is present.
- R6: Simultaneous strobes resolve in fixed priority: exception, then taken branch, then marker, then sequential.
- R7: The size field `dwr_size` selects the operand length: 2'b00 = byte (bits 7:0, 2 nibbles), 2'b01 = word (bits 15:0, 4 nibbles), 2'b10 = long word (bits 31:0, 8 nibbles). Nibbles leave on `dd_o` least-significant first, and operands are sent in the order they were accepted.
- R8: `dd_valid_o` is high for exactly one cycle per operand nibble. While it is low, `dd_o` reads 4'b0000.
- R9: Up to 4 operands wait in a FIFO. `stall_req_o` is high exactly while the FIFO is full. A write presented while `stall_req_o` is high is not taken, and it is accepted once the request drops, so no operand is lost.
- R10: A synchronous active-high reset empties the FIFO, aborts any operand being sent, drives `pst_o` and `dd_o` to 4'b0000 and clears `dd_valid_o` and `stall_req_o`.
- R11: The reserved size code 2'b11 is sent as a long word (8 nibbles).
- R12: Operand streaming has no effect on the status port. Status codes stay correct in every cycle while data is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_seq | input | 1 | Sequential instruction retired this cycle |
| ev_branch | input | 1 | First instruction at a taken-branch target retired |
| ev_exc | input | 1 | Exception handler entered |
| ev_mark | input | 1 | Software marker pulse retired |
| ev_dwr | input | 1 | Debug-data write request; held until accepted |
| dwr_size | input | 2 | Operand size: 00 byte, 01 word, 10/11 long word |
| dwr_data | input | 32 | Operand value, right-aligned |
| stall_req_o | output | 1 | FIFO full; core must hold its write |
| pst_o | output | 4 | Registered status code |
| dd_o | output | 4 | Operand nibble, 0000 when idle |
| dd_valid_o | output | 1 | `dd_o` carries an operand nibble |

## Verification
The bench drives every single strobe and several pairs and triples at once. An encoder with the wrong priority, or one that reads the strobes a cycle late, would show the wrong code on `pst_o`. It streams all three sizes plus the reserved size, with distinct nibble values in each operand. A design that sent the high nibble first, sent the unused upper bits of a byte, or skipped a nibble would miscompare in the scoreboard. A burst of long words fills the queue. A design that dropped or overwrote an operand under stall would leave the scoreboard short. A reset in the middle of a burst must leave nothing behind on the data port. A branch sent while an operand streams checks that the two ports stay independent.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [3:0] {
      ST_NONE   = 4'b0000,
      ST_SEQ    = 4'b0001,
      ST_MARK   = 4'b0100,
      ST_BRANCH = 4'b0101,
      ST_EXCEPT = 4'b1100
   } trc_status_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } opnd_size_e;

   localparam int unsigned STATUS_W = 4;
   localparam int unsigned SIZE_W   = 2;

endpackage

// File: rtl/trc_status_enc.sv
module trc_status_enc
   import trc_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                ev_seq,
   input  logic                ev_branch,
   input  logic                ev_exc,
   input  logic                ev_mark,
   output logic [STATUS_W-1:0] pst_o
);

   logic [STATUS_W-1:0] code_d;

   // fixed priority: exception > branch target > marker > sequential
   always_comb begin
      code_d = ST_NONE;
      if (ev_exc)         code_d = ST_EXCEPT;
      else if (ev_branch) code_d = ST_BRANCH;
      else if (ev_mark)   code_d = ST_MARK;
      else if (ev_seq)    code_d = ST_SEQ;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [STATUS_W-1:0] code_q;
         always_ff @(posedge clk) begin
            if (rst) code_q <= ST_NONE;
            else     code_q <= code_d;
         end
         assign pst_o = code_q;

         a_r4_exception_wins: assert property (@(posedge clk) disable iff (rst)
            ev_exc |=> pst_o == 4'b1100);
         a_r3_branch_code: assert property (@(posedge clk) disable iff (rst)
            (ev_branch && !ev_exc) |=> pst_o == 4'b0101);
         a_r1_idle_code: assert property (@(posedge clk) disable iff (rst)
            !(ev_seq || ev_branch || ev_exc || ev_mark) |=> pst_o == 4'b0000);
      end else begin : g_comb
         assign pst_o = code_d;
      end
   endgenerate

endmodule

// File: rtl/trc_opnd_fifo.sv
module trc_opnd_fifo #(
   parameter int W     = 34,
   parameter int DEPTH = 4
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         full_o,
   output logic         empty_o
);

   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("trc_opnd_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("trc_opnd_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign dout_o  = mem[rp];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(DEPTH));
   a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
      (full_o && !pop_i) |=> full_o);
   a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i && cnt == CW'(1)) |=> empty_o);

endmodule

// File: rtl/trc_nibble_ser.sv
module trc_nibble_ser
   import trc_pkg::*;
#(
   parameter int DW = 32,
   parameter int NW = 4
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid_i,
   input  logic [DW-1:0]     op_data_i,
   input  logic [SIZE_W-1:0] op_size_i,
   output logic              op_pop_o,
   output logic [NW-1:0]     dd_o,
   output logic              dd_valid_o
);

   localparam int MAXN   = DW / NW;
   localparam int LW     = $clog2(MAXN + 1);
   localparam int N_BYTE = 8 / NW;
   localparam int N_WORD = 16 / NW;
   localparam int N_LONG = MAXN;

   if (DW != 32) begin : g_bad_dw
      $error("trc_nibble_ser: operand width must be 32");
   end
   if ((8 % NW) != 0) begin : g_bad_nw
      $error("trc_nibble_ser: NW must divide a byte");
   end

   logic [DW-1:0] shreg;
   logic [LW-1:0] left, n_load;
   logic          busy, last;

   assign busy       = (left != '0);
   assign last       = (left == LW'(1));
   assign op_pop_o   = op_valid_i && (!busy || last);
   assign dd_valid_o = busy;
   assign dd_o       = busy ? shreg[NW-1:0] : '0;

   always_comb begin
      case (op_size_i)
         SZ_BYTE: n_load = LW'(N_BYTE);
         SZ_WORD: n_load = LW'(N_WORD);
         default: n_load = LW'(N_LONG);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         left  <= '0;
      end else if (op_pop_o) begin
         shreg <= op_data_i;
         left  <= n_load;
      end else if (busy) begin
         shreg <= shreg >> NW;
         left  <= left - 1'b1;
      end
   end

   a_r8_pop_starts_stream: assert property (@(posedge clk) disable iff (rst)
      op_pop_o |=> dd_valid_o);
   a_r7_last_nibble_ends: assert property (@(posedge clk) disable iff (rst)
      (last && !op_valid_i) |=> !dd_valid_o);

endmodule

// File: rtl/trace_status_port.sv
module trace_status_port
   import trc_pkg::*;
#(
   parameter int  FIFO_DEPTH = 4,
   parameter int  DATA_W     = 32,
   parameter int  NIB_W      = 4,
   parameter bit  STATUS_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_seq,
   input  logic              ev_branch,
   input  logic              ev_exc,
   input  logic              ev_mark,
   input  logic              ev_dwr,
   input  logic [1:0]        dwr_size,
   input  logic [DATA_W-1:0] dwr_data,
   output logic              stall_req_o,
   output logic [3:0]        pst_o,
   output logic [NIB_W-1:0]  dd_o,
   output logic              dd_valid_o
);

   localparam int ENTRY_W = DATA_W + SIZE_W;

   logic [ENTRY_W-1:0] f_dout;
   logic               f_full, f_empty, ser_pop;

   trc_status_enc #(.OUT_REG(STATUS_REG)) u_enc (
      .clk       (clk),
      .rst       (rst),
      .ev_seq    (ev_seq),
      .ev_branch (ev_branch),
      .ev_exc    (ev_exc),
      .ev_mark   (ev_mark),
      .pst_o     (pst_o)
   );

   trc_opnd_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push_i  (ev_dwr),
      .din_i   ({dwr_size, dwr_data}),
      .pop_i   (ser_pop),
      .dout_o  (f_dout),
      .full_o  (f_full),
      .empty_o (f_empty)
   );

   trc_nibble_ser #(.DW(DATA_W), .NW(NIB_W)) u_ser (
      .clk        (clk),
      .rst        (rst),
      .op_valid_i (!f_empty),
      .op_data_i  (f_dout[DATA_W-1:0]),
      .op_size_i  (f_dout[ENTRY_W-1:DATA_W]),
      .op_pop_o   (ser_pop),
      .dd_o       (dd_o),
      .dd_valid_o (dd_valid_o)
   );

   assign stall_req_o = f_full;

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (pst_o == 4'b0000 && !dd_valid_o && dd_o == '0 && !stall_req_o));
   a_r9_stall_blocks_entry: assert property (@(posedge clk) disable iff (rst)
      (stall_req_o && !ser_pop) |=> stall_req_o);

endmodule

// File: tb/tb_trace_status_port.sv
`timescale 1ns/1ps
module tb_trace_status_port;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ev_seq = 0, ev_branch = 0, ev_exc = 0, ev_mark = 0, ev_dwr = 0;
   logic [1:0]  dwr_size = 0;
   logic [31:0] dwr_data = 0;
   logic        stall_req_o, dd_valid_o;
   logic [3:0]  pst_o, dd_o;

   int vectors = 0;
   int errors  = 0;
   logic [3:0] expq [$];
   bit saw_stall = 0;

   always #10 clk = ~clk;

   trace_status_port dut (
      .clk(clk), .rst(rst), .ev_seq(ev_seq), .ev_branch(ev_branch), .ev_exc(ev_exc),
      .ev_mark(ev_mark), .ev_dwr(ev_dwr), .dwr_size(dwr_size), .dwr_data(dwr_data),
      .stall_req_o(stall_req_o), .pst_o(pst_o), .dd_o(dd_o), .dd_valid_o(dd_valid_o)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   // scoreboard monitor for the data port (R7, R8)
   always @(negedge clk) begin
      if (!rst) begin
         if (dd_valid_o) begin
            if (expq.size() == 0) check(1'b0, "R8 unexpected nibble", {28'd0, dd_o}, 32'd0);
            else begin
               logic [3:0] e;
               e = expq.pop_front();
               check(dd_o === e, "R7 nibble order", {28'd0, dd_o}, {28'd0, e});
            end
         end else if (dd_o !== 4'b0000) begin
            check(1'b0, "R8 idle data not zero", {28'd0, dd_o}, 32'd0);
         end
      end
   end

   task automatic st(input logic e, b, m, s, input logic [3:0] exp, input string tag);
      ev_exc = e; ev_branch = b; ev_mark = m; ev_seq = s;
      @(posedge clk); #1;
      check(pst_o === exp, tag, {28'd0, pst_o}, {28'd0, exp});
      ev_exc = 0; ev_branch = 0; ev_mark = 0; ev_seq = 0;
   endtask

   task automatic dw(input logic [1:0] sz, input logic [31:0] d);
      int n;
      n = (sz == 2'b00) ? 2 : (sz == 2'b01) ? 4 : 8;
      ev_dwr = 1; dwr_size = sz; dwr_data = d;
      while (stall_req_o) begin
         saw_stall = 1;
         @(posedge clk); #1;
      end
      for (int i = 0; i < n; i++) expq.push_back(4'((d >> (4 * i)) & 32'hF));
      @(posedge clk); #1;
      ev_dwr = 0;
   endtask

   task automatic drain(input string tag);
      int guard = 0;
      while ((expq.size() != 0 || dd_valid_o) && guard < 400) begin
         @(posedge clk); #1;
         guard++;
      end
      check(expq.size() == 0, tag, expq.size(), 0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R1 watchdog: got hung expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check(pst_o === 4'b0 && dd_o === 4'b0 && !dd_valid_o && !stall_req_o,
            "R10 reset state", {pst_o, dd_o, 2'b0, dd_valid_o, stall_req_o}, 0);
      rst = 0;

      // status encodings and priority
      st(0,0,0,0, 4'b0000, "R1 no retirement");
      st(0,0,0,1, 4'b0001, "R2 sequential");
      st(0,1,0,0, 4'b0101, "R3 branch target");
      st(1,0,0,0, 4'b1100, "R4 exception entry");
      st(0,0,1,0, 4'b0100, "R5 marker");
      st(1,1,1,1, 4'b1100, "R6 all strobes");
      st(0,1,1,1, 4'b0101, "R6 branch over marker");
      st(0,0,1,1, 4'b0100, "R6 marker over sequential");
      st(1,0,0,1, 4'b1100, "R6 exception over sequential");
      st(0,0,0,0, 4'b0000, "R1 back to none");

      // operand sizes
      dw(2'b00, 32'hFFFF_FFA5);
      drain("R7 byte drained");
      dw(2'b01, 32'hDEAD_1234);
      drain("R7 word drained");
      dw(2'b10, 32'h8765_4321);
      drain("R7 long drained");
      dw(2'b11, 32'hCAFE_F00D);
      drain("R11 reserved size as long");
      repeat (3) begin
         @(posedge clk); #1;
         check(!dd_valid_o && dd_o === 4'b0, "R8 idle port", {28'd0, dd_o}, 0);
      end

      // R12: status while data streams
      dw(2'b10, 32'h0F1E_2D3C);
      st(0,1,0,0, 4'b0101, "R12 branch during stream");
      st(0,0,0,1, 4'b0001, "R12 sequential during stream");
      drain("R12 stream drained");

      // R9: burst to fill the FIFO
      saw_stall = 0;
      for (int k = 0; k < 7; k++) dw(2'b10, 32'h1111_1111 * (k + 1) ^ 32'h0123_4567);
      check(saw_stall, "R9 stall raised when full", {31'd0, saw_stall}, 1);
      drain("R9 no operand lost");
      check(!stall_req_o, "R9 stall cleared", {31'd0, stall_req_o}, 0);

      // R10: reset mid-burst
      for (int k = 0; k < 4; k++) dw(2'b10, 32'hA5A5_0000 + k);
      rst = 1;
      expq.delete();
      @(posedge clk); #1;
      check(pst_o === 4'b0 && !dd_valid_o && dd_o === 4'b0 && !stall_req_o,
            "R10 reset mid-burst", {pst_o, dd_o, 2'b0, dd_valid_o, stall_req_o}, 0);
      rst = 0;
      repeat (20) @(posedge clk);
      #1;
      check(expq.size() == 0 && !dd_valid_o, "R10 nothing left after reset", expq.size(), 0);
      dw(2'b00, 32'h0000_003C);
      drain("R10 port usable after reset");

      summary();
      $finish;
   end

endmodule